// File: doc/BRIEF.md
# Dual-Lane Square-and-Multiply Exponentiator

This block computes a modular power, result = base^exponent mod modulus, by walking the exponent one bit at a time from the most significant end. Each bit costs one modular squaring of the running result. A one bit adds a modular multiplication of the running result by the base. The block does no arithmetic itself. It drives an external modular multiplier through a request/acknowledge handshake, and that multiplier returns fully reduced products. Because the walk starts at the most significant bit, the running result and the base are the only values the block keeps.

In dual mode the operand words split into two halves. Two independent half-width exponentiations, each with its own base, exponent and modulus, then share one multiplier that is split the same way. This is the arrangement used for the two prime-modulus halves of a remainder-theorem decryption. Both lanes square together at every step. A multiply is issued only for the lanes whose current exponent bit is one. Both lanes move on to the next bit only after the whole step has finished.

The state machine has seven states. IDLE waits for `go_i` and loads the lanes. SQR issues the squaring request and SQW waits for its acknowledge. MUL issues the multiply request and MLW waits for its acknowledge. STEP moves to the next exponent bit. DONE pulses completion and returns to IDLE. The transitions are as follows:
- IDLE to SQR on `go_i`.
- SQR to SQW always.
- SQW to MUL on acknowledge when any enabled lane has a one bit.
- SQW to STEP on acknowledge when no enabled lane has a one bit.
- MUL to MLW always.
- MLW to STEP on acknowledge.
- STEP to SQR while bits remain.
- STEP to DONE after the last bit.
- DONE to IDLE always.

Top module: `modexp_sqmul`

## Requirements
- R1: After reset `busy_o`, `done_o` and `mul_req_o` are 0, `res_o` is 0, and both counts are 0.
- R2: In single mode (`dual_i`=0 at `go_i`) `res_o` equals base_i^expo_i mod mod_i over all W exponent bits, for mod_i > 1.
- R3: Each lane's count equals its number of exponent bits (W in single mode, W/2 in dual mode) plus the number of one bits in its exponent. A lane never counts past twice its width.
- R4: In dual mode lane 0 takes bits [W/2-1:0] of base, exponent and modulus, and lane 1 takes bits [W-1:W/2]. The result is packed as {lane 1, lane 0}. In single mode `mul_en_o[1]` stays 0 and `cnt1_o` reads 0.
- R5: `mul_en_o` bit k enables lane k. Squaring requests carry 2'b11 in dual mode and 2'b01 in single mode. A multiply request enables exactly the lanes whose current bit is one. No multiply request is issued when no enabled lane has a one bit.
- R6: An all-zero exponent gives a result of 1, and each active lane's count then equals its bit count.
- R7: `done_o` is high for exactly one cycle. In the cycle after it, `busy_o` is 0. `res_o` holds its value until the next start.
- R8: `go_i` has no effect while `busy_o` is 1. The operation in progress completes with its original operands.
- R9: `mul_req_o` is a one-cycle pulse. The operands stay stable until `mul_ack_i`. Any acknowledge latency is accepted.
- R10: Every request carries the loaded modulus (packed as in R4) on `mul_m_o` and the captured mode on `mul_dual_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start pulse, accepted in IDLE |
| dual_i | input | 1 | 1 selects two half-width lanes |
| base_i | input | W | Base (halves per lane in dual mode) |
| expo_i | input | W | Exponent (halves per lane in dual mode) |
| mod_i | input | W | Modulus (halves per lane in dual mode) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | W | Result, {lane1, lane0} in dual mode |
| cnt0_o | output | $clog2(2W+1) | Multiplier operations done by lane 0 |
| cnt1_o | output | $clog2(W+1) | Multiplier operations done by lane 1 |
| mul_req_o | output | 1 | Multiplier request pulse |
| mul_dual_o | output | 1 | Multiplier split into halves |
| mul_en_o | output | 2 | Per-lane enable for the request |
| mul_a_o | output | W | First operand (running result) |
| mul_b_o | output | W | Second operand (result or base) |
| mul_m_o | output | W | Modulus operand |
| mul_ack_i | input | 1 | Multiplier done, product valid |
| mul_p_i | input | W | Reduced product |

## Verification
The bench runs dual-mode operations in which the two lanes' exponent bits differ from step to step. A design that multiplied every lane, or skipped the whole multiply step when only one lane had a one bit, would show the wrong per-lane counts and the wrong enable patterns. All-ones and all-zero exponents test the count bounds and the result of 1. A design that mishandled the last bit or the first square would be off by one operation or return the base. Acknowledges arrive with several different latencies, and `go_i` is pulsed with different operands in the middle of a run. A controller that latched early, sampled operands it had not yet held, or restarted while busy would produce a wrong result or change its modulus in flight.

// File: rtl/modexp_pkg.sv
package modexp_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SQR,
        S_SQW,
        S_MUL,
        S_MLW,
        S_STEP,
        S_DONE
    } ctl_state_t;

    localparam int LANES = 2;
endpackage

// File: rtl/modexp_lane.sv
module modexp_lane #(
    parameter int LW = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [LW-1:0]                 base_i,
    input  logic [LW-1:0]                 mod_i,
    input  logic [LW-1:0]                 exp_i,
    input  logic                          latch_i,
    input  logic [LW-1:0]                 prod_i,
    input  logic                          shift_i,
    output logic [LW-1:0]                 res_o,
    output logic [LW-1:0]                 base_o,
    output logic [LW-1:0]                 mod_o,
    output logic                          msb_o,
    output logic [$clog2(2*LW+1)-1:0]     cnt_o
);
    localparam int CW = $clog2(2*LW+1);

    logic [LW-1:0] res_q, base_q, mod_q, exp_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '0;
            base_q <= '0;
            mod_q  <= '0;
            exp_q  <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            res_q  <= LW'(1);
            base_q <= base_i;
            mod_q  <= mod_i;
            exp_q  <= exp_i;
            cnt_q  <= '0;
        end else begin
            if (latch_i) begin
                res_q <= prod_i;
                cnt_q <= cnt_q + CW'(1);
            end
            if (shift_i) begin
                exp_q <= exp_q << 1;
            end
        end
    end

    assign res_o  = res_q;
    assign base_o = base_q;
    assign mod_o  = mod_q;
    assign msb_o  = exp_q[LW-1];
    assign cnt_o  = cnt_q;

    // R3: a lane never performs more than two operations per exponent bit
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(2*LW));

    // R6: a start seeds the running result with 1 and clears the count
    p_load_seed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (res_q == LW'(1)) && (cnt_q == '0));
endmodule

// File: rtl/modexp_ctrl.sv
module modexp_ctrl
    import modexp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic       dual_i,
    input  logic       ack_i,
    input  logic       bit0_i,
    input  logic       bit1_i,
    output logic       load_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       req_o,
    output logic       use_base_o,
    output logic [1:0] en_o,
    output logic [1:0] latch_o,
    output logic       shift_o,
    output logic       dual_o
);
    localparam int HW  = W / 2;
    localparam int BCW = $clog2(W);

    ctl_state_t     st_q, st_d;
    logic [BCW-1:0] bit_q;
    logic           dual_q;
    logic [1:0]     mul_bits, sq_lanes;

    assign mul_bits = {dual_q & bit1_i, bit0_i};
    assign sq_lanes = {dual_q, 1'b1};

    // state register with the bit position and captured mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            bit_q  <= '0;
            dual_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == S_IDLE && go_i) begin
                dual_q <= dual_i;
                bit_q  <= dual_i ? BCW'(HW-1) : BCW'(W-1);
            end else if (st_q == S_STEP && bit_q != '0) begin
                bit_q <= bit_q - BCW'(1);
            end
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (go_i) st_d = S_SQR;
            S_SQR:  st_d = S_SQW;
            S_SQW:  if (ack_i) st_d = (mul_bits != 2'b00) ? S_MUL : S_STEP;
            S_MUL:  st_d = S_MLW;
            S_MLW:  if (ack_i) st_d = S_STEP;
            S_STEP: st_d = (bit_q == '0) ? S_DONE : S_SQR;
            S_DONE: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_o     = 1'b0;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        req_o      = 1'b0;
        use_base_o = 1'b0;
        en_o       = 2'b00;
        latch_o    = 2'b00;
        shift_o    = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                busy_o = 1'b0;
                load_o = go_i;
            end
            S_SQR: begin
                req_o = 1'b1;
                en_o  = sq_lanes;
            end
            S_SQW: begin
                en_o    = sq_lanes;
                latch_o = ack_i ? sq_lanes : 2'b00;
            end
            S_MUL: begin
                req_o      = 1'b1;
                use_base_o = 1'b1;
                en_o       = mul_bits;
            end
            S_MLW: begin
                use_base_o = 1'b1;
                en_o       = mul_bits;
                latch_o    = ack_i ? mul_bits : 2'b00;
            end
            S_STEP: shift_o = 1'b1;
            S_DONE: done_o  = 1'b1;
            default: busy_o = 1'b0;
        endcase
    end

    assign dual_o = dual_q;

    // R9: a request lasts a single cycle
    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    // R7: completion is a one-cycle pulse followed by idle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o);

    // R5: a request always enables at least one lane
    p_en_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> en_o != 2'b00);

    // R4: the upper lane stays off in single mode
    p_upper_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !dual_q) |-> !en_o[1]);

    // R8: a start while busy does not abort the running operation
    p_go_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && go_i) |=> busy_o);
endmodule

// File: rtl/modexp_sqmul.sv
module modexp_sqmul
    import modexp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go_i,
    input  logic                      dual_i,
    input  logic [W-1:0]              base_i,
    input  logic [W-1:0]              expo_i,
    input  logic [W-1:0]              mod_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [W-1:0]              res_o,
    output logic [$clog2(2*W+1)-1:0]  cnt0_o,
    output logic [$clog2(W+1)-1:0]    cnt1_o,
    output logic                      mul_req_o,
    output logic                      mul_dual_o,
    output logic [LANES-1:0]          mul_en_o,
    output logic [W-1:0]              mul_a_o,
    output logic [W-1:0]              mul_b_o,
    output logic [W-1:0]              mul_m_o,
    input  logic                      mul_ack_i,
    input  logic [W-1:0]              mul_p_i
);
    localparam int HW = W / 2;

    logic           load, use_base, shift, dual_q;
    logic [1:0]     latch;
    logic           msb0, msb1;
    logic [W-1:0]   res0, base0, mod0, exp0_ld, prod0;
    logic [HW-1:0]  res1, base1, mod1;
    logic [W-1:0]   res_pk, base_pk, mod_pk;

    // lane 0 takes the full word or, in dual mode, the low half aligned to its top
    assign exp0_ld = dual_i ? {expo_i[HW-1:0], {HW{1'b0}}} : expo_i;
    assign prod0   = dual_q ? {{HW{1'b0}}, mul_p_i[HW-1:0]} : mul_p_i;

    modexp_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go_i),
        .dual_i     (dual_i),
        .ack_i      (mul_ack_i),
        .bit0_i     (msb0),
        .bit1_i     (msb1),
        .load_o     (load),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .req_o      (mul_req_o),
        .use_base_o (use_base),
        .en_o       (mul_en_o),
        .latch_o    (latch),
        .shift_o    (shift),
        .dual_o     (dual_q)
    );

    modexp_lane #(.LW(W)) u_lane0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .base_i  (dual_i ? {{HW{1'b0}}, base_i[HW-1:0]} : base_i),
        .mod_i   (dual_i ? {{HW{1'b0}}, mod_i[HW-1:0]} : mod_i),
        .exp_i   (exp0_ld),
        .latch_i (latch[0]),
        .prod_i  (prod0),
        .shift_i (shift),
        .res_o   (res0),
        .base_o  (base0),
        .mod_o   (mod0),
        .msb_o   (msb0),
        .cnt_o   (cnt0_o)
    );

    modexp_lane #(.LW(HW)) u_lane1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .base_i  (base_i[W-1:HW]),
        .mod_i   (mod_i[W-1:HW]),
        .exp_i   (expo_i[W-1:HW]),
        .latch_i (latch[1]),
        .prod_i  (mul_p_i[W-1:HW]),
        .shift_i (shift),
        .res_o   (res1),
        .base_o  (base1),
        .mod_o   (mod1),
        .msb_o   (msb1),
        .cnt_o   (cnt1_o)
    );

    // pack lane registers onto the shared word
    assign res_pk  = dual_q ? {res1,  res0[HW-1:0]}  : res0;
    assign base_pk = dual_q ? {base1, base0[HW-1:0]} : base0;
    assign mod_pk  = dual_q ? {mod1,  mod0[HW-1:0]}  : mod0;

    assign res_o      = res_pk;
    assign mul_a_o    = res_pk;
    assign mul_b_o    = use_base ? base_pk : res_pk;
    assign mul_m_o    = mod_pk;
    assign mul_dual_o = dual_q;

    // R10: the modulus presented to the multiplier never changes during a run
    p_mod_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$past(load)) |-> $stable(mul_m_o));

    // R9: operands are held while waiting for the acknowledge
    p_opnd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_req_o && !mul_ack_i) |=> $stable(mul_a_o) && $stable(mul_b_o));
endmodule

// File: tb/modexp_sqmul_bench.sv
module modexp_sqmul_bench;
    localparam int W  = 32;
    localparam int HW = W / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0, dual = 1'b0;
    logic [W-1:0] base_v = '0, expo_v = '0, mod_v = '0;
    logic busy, done, mreq, mdual, mack = 1'b0;
    logic [W-1:0] res, ma, mb, mm, mp = '0;
    logic [1:0] men;
    logic [$clog2(2*W+1)-1:0] cnt0;
    logic [$clog2(W+1)-1:0]   cnt1;

    int n_chk = 0, n_fail = 0;
    int lat = 0;

    // monitor state
    bit pend = 0;
    int wcnt = 0;
    logic [W-1:0] cap_a, cap_b, cap_m;
    logic [1:0]   cap_en;
    bit           cap_dual;
    int n_en11, n_en01, n_en10, mon_err;
    logic [W-1:0] exp_m;
    bit           exp_dual;

    always #5 clk = ~clk;

    modexp_sqmul #(.W(W)) u_modexp_sqmul (
        .clk(clk), .rst_n(rst_n), .go_i(go), .dual_i(dual),
        .base_i(base_v), .expo_i(expo_v), .mod_i(mod_v),
        .busy_o(busy), .done_o(done), .res_o(res),
        .cnt0_o(cnt0), .cnt1_o(cnt1),
        .mul_req_o(mreq), .mul_dual_o(mdual), .mul_en_o(men),
        .mul_a_o(ma), .mul_b_o(mb), .mul_m_o(mm),
        .mul_ack_i(mack), .mul_p_i(mp)
    );

    function automatic logic [W-1:0] mulmod(input logic [W-1:0] a, b, m);
        logic [63:0] t;
        t = ({32'b0, a} * {32'b0, b}) % {32'b0, m};
        return t[W-1:0];
    endfunction

    function automatic logic [W-1:0] ref_exp(input logic [W-1:0] b, e, m, input int nb);
        logic [W-1:0] r;
        r = 1;
        for (int i = nb - 1; i >= 0; i--) begin
            r = mulmod(r, r, m);
            if (e[i]) r = mulmod(r, b, m);
        end
        return r;
    endfunction

    function automatic int pop(input logic [W-1:0] v);
        int c;
        c = 0;
        for (int i = 0; i < W; i++) c += int'(v[i]);
        return c;
    endfunction

    // behavioural multiplier, driven away from the active edge
    always @(negedge clk) begin
        mack = 1'b0;
        if (pend) begin
            if (wcnt == 0) begin
                if (ma != cap_a || mb != cap_b || mm != cap_m) mon_err++;
                if (cap_dual) begin
                    mp[HW-1:0] = cap_en[0] ? mulmod({16'b0, cap_a[HW-1:0]}, {16'b0, cap_b[HW-1:0]},
                                                    {16'b0, cap_m[HW-1:0]}) : 32'b0;
                    mp[W-1:HW] = cap_en[1] ? mulmod({16'b0, cap_a[W-1:HW]}, {16'b0, cap_b[W-1:HW]},
                                                    {16'b0, cap_m[W-1:HW]}) : 32'b0;
                end else begin
                    mp = mulmod(cap_a, cap_b, cap_m);
                end
                mack = 1'b1;
                pend = 0;
            end else begin
                wcnt--;
            end
        end
        if (mreq) begin
            pend = 1;
            wcnt = lat;
            cap_a = ma; cap_b = mb; cap_m = mm; cap_en = men; cap_dual = mdual;
            if (mm != exp_m || mdual != exp_dual) mon_err++;
            case (men)
                2'b11: n_en11++;
                2'b01: n_en01++;
                2'b10: n_en10++;
                default: mon_err++;
            endcase
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic start_op(input bit d, input logic [W-1:0] b, e, m, input int l);
        @(negedge clk);
        dual = d; base_v = b; expo_v = e; mod_v = m; lat = l;
        exp_m = m; exp_dual = d;
        n_en11 = 0; n_en01 = 0; n_en10 = 0; mon_err = 0;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic finish_op(input string tag);
        bit seen;
        logic [W-1:0] held;
        seen = 0;
        for (int i = 0; i < 50000; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        check(seen, {tag, " watchdog"}, 0, 1);
        held = res;
        @(negedge clk);
        check(!done && !busy, {tag, " R7 done one cycle then idle"}, {done, busy}, 0);
        repeat (3) @(negedge clk);
        check(res == held, {tag, " R7 result held"}, res, held);
        check(mon_err == 0, {tag, " R9 R10 handshake operands/modulus"}, mon_err, 0);
    endtask

    task automatic t_reset;
        check(!busy && !done && !mreq, "R1 reset control", {busy, done, mreq}, 0);
        check(res == 0 && cnt0 == 0 && cnt1 == 0, "R1 reset data", {res, 7'(cnt0), 6'(cnt1)}, 0);
    endtask

    task automatic t_single(input logic [W-1:0] b, e, m, input int l);
        logic [W-1:0] r;
        r = ref_exp(b, e, m, W);
        start_op(0, b, e, m, l);
        finish_op("single");
        check(res == r, "R2 single result", res, r);
        check(int'(cnt0) == W + pop(e), "R3 single count", cnt0, W + pop(e));
        check(cnt1 == 0 && n_en10 == 0, "R4 upper lane idle in single", cnt1, 0);
        check(n_en01 == W + pop(e) && n_en11 == 0, "R5 single enables", n_en01, W + pop(e));
    endtask

    task automatic t_zero(input int l);
        start_op(0, 32'h1234_5678, 32'h0, 32'd1000003, l);
        finish_op("zero");
        check(res == 1, "R6 zero exponent result", res, 1);
        check(int'(cnt0) == W, "R6 zero exponent count", cnt0, W);
    endtask

    task automatic t_dual(input logic [HW-1:0] b0, e0, m0, b1, e1, m1, input int l);
        logic [W-1:0] r0, r1;
        int both, only0, only1;
        r0 = ref_exp({16'b0, b0}, {16'b0, e0}, {16'b0, m0}, HW);
        r1 = ref_exp({16'b0, b1}, {16'b0, e1}, {16'b0, m1}, HW);
        both = pop({16'b0, e0 & e1});
        only0 = pop({16'b0, e0 & ~e1});
        only1 = pop({16'b0, e1 & ~e0});
        start_op(1, {b1, b0}, {e1, e0}, {m1, m0}, l);
        finish_op("dual");
        check(res == {r1[HW-1:0], r0[HW-1:0]}, "R4 dual packed result", res, {r1[HW-1:0], r0[HW-1:0]});
        check(int'(cnt0) == HW + pop({16'b0, e0}), "R3 dual lane0 count", cnt0, HW + pop({16'b0, e0}));
        check(int'(cnt1) == HW + pop({16'b0, e1}), "R3 dual lane1 count", cnt1, HW + pop({16'b0, e1}));
        check(n_en11 == HW + both, "R5 dual shared requests", n_en11, HW + both);
        check(n_en01 == only0 && n_en10 == only1, "R5 dual single-lane multiplies",
              {n_en01, n_en10}, {only0, only1});
    endtask

    task automatic t_busy_go;
        logic [W-1:0] r;
        r = ref_exp(32'h0BAD_F00D, 32'hC001_0203, 32'hFFFF_FFC5, W);
        start_op(0, 32'h0BAD_F00D, 32'hC001_0203, 32'hFFFF_FFC5, 1);
        repeat (20) @(negedge clk);
        dual = 1; base_v = 32'h5; expo_v = 32'h3; mod_v = 32'h00070007;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        check(busy, "R8 still busy after go", busy, 1);
        finish_op("busygo");
        check(res == r, "R8 result from original operands", res, r);
        check(int'(cnt0) == W + pop(32'hC001_0203), "R8 count unchanged", cnt0, W + pop(32'hC001_0203));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_single(32'd7, 32'hD, 32'd1000003, 0);
        t_single(32'hDEAD_BEEF, 32'hF0F0_A5C3, 32'hFFFF_FFFB, 3);
        t_single(32'h0001_2345, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 2);
        t_zero(4);
        t_dual(16'd1234, 16'hA5A5, 16'd65521, 16'd999, 16'h5A0F, 16'd65519, 2);
        t_dual(16'd31337, 16'hFFFF, 16'd40961, 16'd77, 16'h0000, 16'd257, 0);
        t_busy_go;
        t_single(32'd3, 32'h8000_0001, 32'd97, 5);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule